// File: doc/BRIEF.md
# Transaction Status Queue with Completion Flag

This block keeps a short ordered record of finished bus transactions so that a processor can work on one completed transaction while the serial engine is already finishing the next one. Each time a transaction completes, the engine pushes one status byte. The byte carries the endpoint number, the transfer direction and the buffer bank that was used. The entry at the front of the record sits in a read-only holding register. A completion flag tells the processor that the holding register is valid.

The processor acknowledges an entry by writing one to the completion flag. That write retires the entry that was shown. If another entry is waiting, it moves into the holding register at once and the flag stays up. If nothing is waiting, the flag drops and the holding register keeps its old contents. The block holds four entries in total. A completion that arrives when all four are occupied is thrown away and raises a sticky overflow bit, which software clears by writing one to it.

Top module: `txn_status_queue`

## Requirements
- R1: The status byte has the endpoint number in bits 7:4, the direction bit in bit 3 (1 = transmit, 0 = receive) and the bank bit in bit 2 (1 = odd bank).
- R2: Bits 1:0 of the status byte always read zero.
- R3: After reset the completion flag, the overflow bit and the status byte are all zero.
- R4: A push while the flag is low appears in the status byte one cycle later, with the flag high.
- R5: Up to four entries are held, and they are presented in the order they were pushed.
- R6: Clearing the flag while another entry is waiting shows that entry on the next cycle, and the flag stays high.
- R7: Clearing the flag when no entry is waiting lowers the flag on the next cycle, and the status byte keeps its value.
- R8: A clear while the flag is already low has no effect on the flag, on the status byte or on the stored entries.
- R9: A push that arrives while four entries are held, and no clear is given in the same cycle, is discarded and sets the overflow bit one cycle later.
- R10: Writing one to the overflow clear input lowers the overflow bit on the next cycle, unless a discard happens in the same cycle.
- R11: A push and a flag clear in the same cycle both take effect: the front entry is retired, the new entry is appended, and no overflow occurs, even when the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Transaction completion strobe from the engine |
| push_ep_i | input | 4 | Endpoint number of the completed transaction |
| push_tx_i | input | 1 | 1 for a transmit transaction, 0 for a receive transaction |
| push_odd_i | input | 1 | 1 if the odd buffer bank was used |
| clr_done_i | input | 1 | Write-one pulse that clears the completion flag |
| clr_ovf_i | input | 1 | Write-one pulse that clears the overflow bit |
| stat_o | output | 8 | Status byte of the front entry |
| done_o | output | 1 | Completion flag; stat_o is valid while it is high |
| ovf_o | output | 1 | Sticky overflow bit |

## Verification
A wrong read pointer or a wrong entry count shows up on stat_o at the first clear that should present a waiting entry. A mistake in the flag logic shows up one cycle after a clear or a push, as a flag that is high while nothing is stored or low while an entry is waiting. A miscounted capacity appears either as a fifth entry that comes out during the drain or as a missing overflow bit on the cycle after the discarded push. For these reasons every scenario drains the whole queue and compares each byte and each flag value, cycle by cycle, against an order the bench keeps itself.

// File: rtl/txn_stat_pkg.sv
package txn_stat_pkg;
  localparam int EP_W   = 4;
  localparam int STAT_W = 8;

  typedef struct packed {
    logic [EP_W-1:0] ep;
    logic            tx;
    logic            odd;
    logic [1:0]      rsvd;
  } stat_byte_t;

  // Packs one completion record; the reserved bits are always zero.
  function automatic stat_byte_t make_stat(input logic [EP_W-1:0] ep,
                                           input logic tx,
                                           input logic odd);
    stat_byte_t s;
    s.ep   = ep;
    s.tx   = tx;
    s.odd  = odd;
    s.rsvd = 2'b00;
    return s;
  endfunction

  // Ring pointer advance for a depth that need not be a power of two.
  function automatic int unsigned ring_next(input int unsigned p,
                                            input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/stat_backlog.sv
module stat_backlog #(
  parameter int W     = 8,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_i,
  output logic [W-1:0] rd_data_o,
  output logic         empty_o,
  output logic         full_o
);
  import txn_stat_pkg::*;

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  assign empty_o   = (count == '0);
  assign full_o    = (count == CNT_FULL);
  assign rd_data_o = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_i) mem[wr_ptr] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_i) wr_ptr <= PW'(ring_next(int'(wr_ptr), DEPTH));
      if (rd_i) rd_ptr <= PW'(ring_next(int'(rd_ptr), DEPTH));
      case ({wr_i, rd_i})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R9: the controller never writes into a full backlog without a pop
  p_no_write_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |-> (!full_o || rd_i));
  // R5: never pop an empty backlog
  p_no_read_when_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |-> !empty_o);
endmodule

// File: rtl/stat_head.sv
module stat_head #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         retire_i,
  output logic [W-1:0] stat_o,
  output logic         done_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_o <= '0;
      done_o <= 1'b0;
    end else if (load_i) begin
      stat_o <= load_data_i;
      done_o <= 1'b1;
    end else if (retire_i) begin
      done_o <= 1'b0;
    end
  end

  // R7: a retire with no reload keeps the byte and lowers the flag
  p_retire_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && !load_i) |=> (!done_o && $stable(stat_o)));
endmodule

// File: rtl/sticky_bit.sv
module sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  // R10: a clear with no set lowers the bit
  p_clear_lowers_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/txn_status_queue.sv
module txn_status_queue #(
  parameter int ENTRIES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_i,
  input  logic [3:0] push_ep_i,
  input  logic       push_tx_i,
  input  logic       push_odd_i,
  input  logic       clr_done_i,
  input  logic       clr_ovf_i,
  output logic [7:0] stat_o,
  output logic       done_o,
  output logic       ovf_o
);
  import txn_stat_pkg::*;

  // One entry lives in the holding register; the rest wait in the backlog.
  localparam int BACKLOG = ENTRIES - 1;

  stat_byte_t push_byte;
  logic [STAT_W-1:0] bl_head;
  logic bl_empty, bl_full;

  // Named internal events
  logic retire;      // flag cleared while it was high
  logic advance;     // next backlog entry moves to the holding register
  logic bypass;      // pushed byte goes straight to the holding register
  logic bl_write;    // pushed byte is appended to the backlog
  logic drop;        // pushed byte is discarded
  logic head_load;
  logic [STAT_W-1:0] head_data;

  assign push_byte = make_stat(push_ep_i, push_tx_i, push_odd_i);

  assign retire    = done_o && clr_done_i;
  assign advance   = retire && !bl_empty;
  assign bypass    = push_i && (!done_o || (retire && bl_empty));
  assign bl_write  = push_i && !bypass && (!bl_full || advance);
  assign drop      = push_i && !bypass && bl_full && !advance;
  assign head_load = advance || bypass;
  assign head_data = advance ? bl_head : push_byte;

  stat_backlog #(.W(STAT_W), .DEPTH(BACKLOG)) u_backlog (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (bl_write),
    .wr_data_i (push_byte),
    .rd_i      (advance),
    .rd_data_o (bl_head),
    .empty_o   (bl_empty),
    .full_o    (bl_full)
  );

  stat_head #(.W(STAT_W)) u_head (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (head_load),
    .load_data_i (head_data),
    .retire_i    (retire),
    .stat_o      (stat_o),
    .done_o      (done_o)
  );

  sticky_bit u_ovf (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (drop),
    .clr_i (clr_ovf_i),
    .q_o   (ovf_o)
  );

  // R4: a push into an idle block raises the flag on the next cycle
  p_push_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !done_o) |=> done_o);
  // R4: a low flag means nothing is waiting in the backlog
  p_idle_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> bl_empty);
  // R6: a clear with a waiting entry presents that entry, flag high
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && clr_done_i && !bl_empty) |=> (done_o && stat_o == $past(bl_head)));
  // R8: a clear while the flag is low changes nothing
  p_idle_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_o && clr_done_i && !push_i) |=> (!done_o && $stable(stat_o)));
  // R9: a discarded push raises the overflow bit
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf_o);
  // R11: a push paired with a clear is never discarded
  p_push_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && retire) |-> !drop);
  // R2: the reserved bits are zero at the port
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o[1:0] == 2'b00);
endmodule

// File: tb/txn_status_queue_tb.sv
`timescale 1ns/1ps
module txn_status_queue_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       push_i;
  logic [3:0] push_ep_i;
  logic       push_tx_i, push_odd_i, clr_done_i, clr_ovf_i;
  logic [7:0] stat_o;
  logic       done_o, ovf_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  txn_status_queue u_dut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_ep_i(push_ep_i),
    .push_tx_i(push_tx_i), .push_odd_i(push_odd_i), .clr_done_i(clr_done_i),
    .clr_ovf_i(clr_ovf_i), .stat_o(stat_o), .done_o(done_o), .ovf_o(ovf_o)
  );

  // Bench view of the status byte layout (R1, R2).
  function automatic logic [7:0] exp_byte(input logic [3:0] ep, input logic tx,
                                          input logic odd);
    return (8'(ep) << 4) | (tx ? 8'h08 : 8'h00) | (odd ? 8'h04 : 8'h00);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  // One clock of stimulus; returns after the edge, with the outputs settled.
  task automatic step(input logic p, input logic [3:0] ep, input logic tx,
                      input logic odd, input logic cd, input logic co);
    @(negedge clk);
    push_i = p; push_ep_i = ep; push_tx_i = tx; push_odd_i = odd;
    clr_done_i = cd; clr_ovf_i = co;
    @(negedge clk);
    push_i = 1'b0; clr_done_i = 1'b0; clr_ovf_i = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    push_i = 0; push_ep_i = 0; push_tx_i = 0; push_odd_i = 0;
    clr_done_i = 0; clr_ovf_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3", "stat after reset", stat_o, 8'h00);
    check("R3", "done after reset", 8'(done_o), 8'h00);
    check("R3", "ovf after reset", 8'(ovf_o), 8'h00);
  endtask

  task automatic t_single;
    step(1, 4'd5, 1, 0, 0, 0);
    check("R1", "transmit entry byte", stat_o, exp_byte(4'd5, 1, 0));
    check("R2", "reserved bits", 8'(stat_o[1:0]), 8'h00);
    check("R4", "flag after push", 8'(done_o), 8'h01);
    step(0, 0, 0, 0, 1, 0);
    check("R7", "flag after last clear", 8'(done_o), 8'h00);
    check("R7", "byte held", stat_o, exp_byte(4'd5, 1, 0));
    step(0, 0, 0, 0, 1, 0);
    check("R8", "flag after idle clear", 8'(done_o), 8'h00);
    check("R8", "byte after idle clear", stat_o, exp_byte(4'd5, 1, 0));
    step(1, 4'd9, 0, 1, 0, 0);
    check("R1", "receive odd entry", stat_o, exp_byte(4'd9, 0, 1));
    step(0, 0, 0, 0, 1, 0);
  endtask

  task automatic t_fill_overflow;
    logic [7:0] q [4];
    q[0] = exp_byte(4'd10, 0, 1);
    q[1] = exp_byte(4'd3, 1, 1);
    q[2] = exp_byte(4'd15, 1, 0);
    q[3] = exp_byte(4'd0, 0, 0);
    step(1, 4'd10, 0, 1, 0, 0);
    step(1, 4'd3, 1, 1, 0, 0);
    step(1, 4'd15, 1, 0, 0, 0);
    step(1, 4'd0, 0, 0, 0, 0);
    check("R9", "no ovf at four entries", 8'(ovf_o), 8'h00);
    check("R5", "front after fill", stat_o, q[0]);
    step(1, 4'd7, 1, 1, 0, 0);
    check("R9", "ovf after fifth push", 8'(ovf_o), 8'h01);
    for (int i = 1; i < 4; i++) begin
      step(0, 0, 0, 0, 1, 0);
      check("R6", "flag stays high", 8'(done_o), 8'h01);
      check("R5", "drain order", stat_o, q[i]);
    end
    step(0, 0, 0, 0, 1, 0);
    check("R9", "dropped entry absent", 8'(done_o), 8'h00);
    check("R7", "last byte held", stat_o, q[3]);
    check("R9", "ovf still sticky", 8'(ovf_o), 8'h01);
    step(0, 0, 0, 0, 0, 1);
    check("R10", "ovf cleared", 8'(ovf_o), 8'h00);
  endtask

  task automatic t_push_and_clear;
    step(1, 4'd1, 0, 0, 0, 0);
    step(1, 4'd2, 1, 0, 1, 0);
    check("R11", "bypass on clear", stat_o, exp_byte(4'd2, 1, 0));
    check("R11", "flag on bypass", 8'(done_o), 8'h01);
    step(1, 4'd4, 0, 1, 0, 0);
    step(1, 4'd6, 1, 1, 1, 0);
    check("R11", "advance with append", stat_o, exp_byte(4'd4, 0, 1));
    step(0, 0, 0, 0, 1, 0);
    check("R11", "appended entry", stat_o, exp_byte(4'd6, 1, 1));
    step(0, 0, 0, 0, 1, 0);
    check("R7", "empty after pair", 8'(done_o), 8'h00);
  endtask

  task automatic t_full_push_clear;
    logic [7:0] q [5];
    for (int i = 0; i < 4; i++) begin
      q[i] = exp_byte(4'(i + 8), i[0], i[1]);
      step(1, 4'(i + 8), i[0], i[1], 0, 0);
    end
    q[4] = exp_byte(4'd12, 1, 1);
    step(1, 4'd12, 1, 1, 1, 0);
    check("R11", "no ovf on full push+clear", 8'(ovf_o), 8'h00);
    check("R11", "front after full pair", stat_o, q[1]);
    for (int i = 2; i < 5; i++) begin
      step(0, 0, 0, 0, 1, 0);
      check("R5", "full pair drain", stat_o, q[i]);
    end
    step(0, 0, 0, 0, 1, 0);
    check("R7", "drained", 8'(done_o), 8'h00);
  endtask

  initial begin
    t_reset;
    t_single;
    t_fill_overflow;
    t_push_and_clear;
    t_full_push_clear;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule